// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

A register-mapped watchdog that counts clock ticks and compares the count against two programmable thresholds. The earlier threshold raises a warning interrupt, which gives software a last chance to react. The later threshold issues a reset request pulse to the system reset logic. Software keeps the system alive by writing a clear command that sets the tick count back to zero. A sticky flag records that a bite happened. This flag survives the system reset that the bite causes, so that software can read it after the reboot.

The block has two reset inputs. The power-on reset clears everything. The system reset clears everything except the bite flag. Both threshold registers are full data width and hold raw clock ticks. The counter is `CNT_W` bits wide and saturates at its maximum value. A parameter selects one of two fixed register layouts.

Top module: `dual_stage_watchdog`

## Requirements
- R1: After the power-on reset, both outputs are low and every readable register reads 0. These are the control, count, bark threshold, bite threshold and status registers.
- R2: The default layout (`ALT_MAP`=0) places the registers at these byte offsets. The keep-alive/count register is at 0x04, control at 0x08, status at 0x0C, bark threshold at 0x10 and bite threshold at 0x14. A read returns data on `rd_data` in the cycle after the read strobe.
- R3: With `ALT_MAP`=1, the same registers sit at 0x38, 0x40, 0x44, 0x4C and 0x5C, in that order.
- R4: A write to the keep-alive register with bit 0 set clears the count to 0 at that clock edge. A write to it with bit 0 clear has no effect.
- R5: While control bit 0 (run) is set, the count rises by exactly one per clock. Reading the keep-alive register returns the count.
- R6: The count saturates at 2^CNT_W-1 and does not wrap.
- R7: With control bits 0 and 1 (interrupt enable) both set, `bark_irq` goes high one clock after the count reaches the bark threshold. It then stays high until a keep-alive clear or until counting is disabled.
- R8: With control bit 1 clear, `bark_irq` stays low whatever the count.
- R9: When the count reaches the bite threshold while running, `bite_req` goes high one clock later for exactly `PULSE_CYC` clocks. It fires only once until the count is cleared or counting is disabled.
- R10: Writing 0 to control freezes the count, drops `bark_irq` within one clock and prevents any bite.
- R11: Status bit 0 is set by a bite. It stays set through `sys_rst_n` and is cleared only by `por_n`. Bus writes cannot change it.
- R12: Writes to unmapped offsets change no register. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Watchdog clock; one tick per cycle |
| por_n | input | 1 | Asynchronous power-on reset, active low; clears all state |
| sys_rst_n | input | 1 | Asynchronous system reset, active low; clears all but the bite flag |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data |
| bark_irq | output | 1 | Warning interrupt, level high |
| bite_req | output | 1 | Reset request pulse |

## Verification
Two states are hardest to reach from the ports. One is a count held at its saturated maximum. The other is the bite flag after the system reset that follows a bite. The bench builds the block with an 8-bit counter, so saturation is reached within a few hundred cycles and the bite window at the top of the range can be checked cycle by cycle. The bench then acts as the reset controller. It pulses `sys_rst_n` after the bite and reads the flag back, then pulses `por_n` and reads it again. The bench also sweeps the bark and bite thresholds over small values, including zero, and compares every cycle against an arithmetic window.

// File: rtl/dsw_pkg.sv
`timescale 1ns/1ps
package dsw_pkg;

   // Control register bit positions (software-visible)
   localparam int CTRL_RUN_BIT = 0;
   localparam int CTRL_IRQ_BIT = 1;
   localparam int CTRL_W       = 2;

   // Register selector produced by the address decoder
   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_KICK,
      SEL_CTRL,
      SEL_STAT,
      SEL_BARK,
      SEL_BITE
   } dsw_sel_e;

   // Byte offsets of the two layouts
   localparam int STD_KICK = 'h04;
   localparam int STD_CTRL = 'h08;
   localparam int STD_STAT = 'h0C;
   localparam int STD_BARK = 'h10;
   localparam int STD_BITE = 'h14;

   localparam int ALT_KICK = 'h38;
   localparam int ALT_CTRL = 'h40;
   localparam int ALT_STAT = 'h44;
   localparam int ALT_BARK = 'h4C;
   localparam int ALT_BITE = 'h5C;

endpackage

// File: rtl/dsw_counter.sv
`timescale 1ns/1ps
module dsw_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             kick_i,
   output logic [CNT_W-1:0] cnt_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;
   logic             at_max;

   assign at_max = (cnt_q == CNT_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (kick_i) begin
         cnt_q <= '0;
      end else if (run_i && !at_max) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_o = cnt_q;

   assert_kick_zero_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      kick_i |=> (cnt_q == '0));

   assert_step_one_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !kick_i && !at_max) |=> (cnt_q == $past(cnt_q) + 1'b1));

   assert_no_wrap_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (at_max && !kick_i) |=> (cnt_q == CNT_MAX));

   assert_frozen_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i && !kick_i) |=> $stable(cnt_q));

endmodule

// File: rtl/dsw_alarm.sv
`timescale 1ns/1ps
module dsw_alarm #(
   parameter int CNT_W     = 32,
   parameter int DATA_W    = 32,
   parameter int PULSE_CYC = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_i,
   input  logic              irq_en_i,
   input  logic              kick_i,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic [DATA_W-1:0] bark_t_i,
   input  logic [DATA_W-1:0] bite_t_i,
   output logic              bark_irq_o,
   output logic              bite_req_o,
   output logic              bite_fire_o
);

   localparam int PW = $clog2(PULSE_CYC + 1);
   localparam logic [PW-1:0] PULSE_LOAD = PW'(PULSE_CYC);

   logic [DATA_W-1:0] cnt_ext;
   logic              bark_q;
   logic              fired_q;
   logic              req_q;
   logic [PW-1:0]     left_q;
   logic              bark_d;
   logic              hit;

   always_comb begin
      cnt_ext = '0;
      cnt_ext[CNT_W-1:0] = cnt_i;
   end

   assign bark_d = run_i && irq_en_i && !kick_i && (cnt_ext >= bark_t_i);
   assign hit    = run_i && !kick_i && !fired_q && (cnt_ext >= bite_t_i);

   // warning stage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bark_q <= 1'b0;
      else        bark_q <= bark_d;
   end

   // reset-request stage: one armed shot per timeout
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fired_q <= 1'b0;
      end else if (kick_i || !run_i) begin
         fired_q <= 1'b0;
      end else if (hit) begin
         fired_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q  <= 1'b0;
         left_q <= '0;
      end else if (hit) begin
         req_q  <= 1'b1;
         left_q <= PULSE_LOAD;
      end else if (left_q > PW'(1)) begin
         left_q <= left_q - 1'b1;
      end else begin
         req_q  <= 1'b0;
         left_q <= '0;
      end
   end

   assign bark_irq_o  = bark_q;
   assign bite_req_o  = req_q;
   assign bite_fire_o = hit;

   assert_irq_gated_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en_i |=> !bark_q);

   assert_stop_drops_bark_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> !bark_q);

   assert_single_shot_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (fired_q && $past(fired_q)) |-> !$rose(req_q));

   assert_pulse_start_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_q) |-> (left_q == PULSE_LOAD));

endmodule

// File: rtl/dsw_regs.sv
`timescale 1ns/1ps
module dsw_regs
   import dsw_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 32,
   parameter int CNT_W   = 32,
   parameter bit ALT_MAP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              por_n,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic              bite_fire_i,
   output logic              run_o,
   output logic              irq_en_o,
   output logic [DATA_W-1:0] bark_t_o,
   output logic [DATA_W-1:0] bite_t_o,
   output logic              kick_o,
   output logic              status_o
);

   logic [ADDR_W-1:0] off_kick, off_ctrl, off_stat, off_bark, off_bite;

   generate
      if (ALT_MAP) begin : g_alt_map
         assign off_kick = ADDR_W'(ALT_KICK);
         assign off_ctrl = ADDR_W'(ALT_CTRL);
         assign off_stat = ADDR_W'(ALT_STAT);
         assign off_bark = ADDR_W'(ALT_BARK);
         assign off_bite = ADDR_W'(ALT_BITE);
      end else begin : g_std_map
         assign off_kick = ADDR_W'(STD_KICK);
         assign off_ctrl = ADDR_W'(STD_CTRL);
         assign off_stat = ADDR_W'(STD_STAT);
         assign off_bark = ADDR_W'(STD_BARK);
         assign off_bite = ADDR_W'(STD_BITE);
      end
   endgenerate

   dsw_sel_e sel;

   always_comb begin
      if      (addr_i == off_kick) sel = SEL_KICK;
      else if (addr_i == off_ctrl) sel = SEL_CTRL;
      else if (addr_i == off_stat) sel = SEL_STAT;
      else if (addr_i == off_bark) sel = SEL_BARK;
      else if (addr_i == off_bite) sel = SEL_BITE;
      else                         sel = SEL_NONE;
   end

   logic [CTRL_W-1:0] ctrl_q;
   logic [DATA_W-1:0] bark_q, bite_q, rdata_q, rdata_d;
   logic              stat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         bark_q <= '0;
         bite_q <= '0;
      end else if (wr_i) begin
         case (sel)
            SEL_CTRL: ctrl_q <= wdata_i[CTRL_W-1:0];
            SEL_BARK: bark_q <= wdata_i;
            SEL_BITE: bite_q <= wdata_i;
            default:  ;
         endcase
      end
   end

   // sticky bite flag lives in the power-on domain only
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)           stat_q <= 1'b0;
      else if (bite_fire_i) stat_q <= 1'b1;
   end

   always_comb begin
      rdata_d = '0;
      case (sel)
         SEL_KICK: rdata_d[CNT_W-1:0]  = cnt_i;
         SEL_CTRL: rdata_d[CTRL_W-1:0] = ctrl_q;
         SEL_STAT: rdata_d[0]          = stat_q;
         SEL_BARK: rdata_d             = bark_q;
         SEL_BITE: rdata_d             = bite_q;
         default:  rdata_d             = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rdata_q <= '0;
      else if (rd_i) rdata_q <= rdata_d;
   end

   assign rdata_o  = rdata_q;
   assign run_o    = ctrl_q[CTRL_RUN_BIT];
   assign irq_en_o = ctrl_q[CTRL_IRQ_BIT];
   assign bark_t_o = bark_q;
   assign bite_t_o = bite_q;
   assign kick_o   = wr_i && (sel == SEL_KICK) && wdata_i[0];
   assign status_o = stat_q;

   assert_status_sticky_R11 : assert property (@(posedge clk) disable iff (!por_n)
      stat_q |=> stat_q);

   assert_ctrl_write_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && addr_i == off_ctrl) |=> (run_o == $past(wdata_i[CTRL_RUN_BIT])));

   assert_unmapped_quiet_R12 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && sel == SEL_NONE) |=> ($stable(ctrl_q) && $stable(bark_q) && $stable(bite_q)));

endmodule

// File: rtl/dual_stage_watchdog.sv
`timescale 1ns/1ps
module dual_stage_watchdog #(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int CNT_W     = 32,
   parameter int PULSE_CYC = 4,
   parameter bit ALT_MAP   = 1'b0
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              sys_rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              bark_irq,
   output logic              bite_req
);

   generate
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt_w
         $error("dual_stage_watchdog: CNT_W must lie in 2..DATA_W");
      end
      if (ADDR_W < 7) begin : g_bad_addr_w
         $error("dual_stage_watchdog: ADDR_W must be at least 7 to reach every offset");
      end
      if (PULSE_CYC < 1) begin : g_bad_pulse
         $error("dual_stage_watchdog: PULSE_CYC must be at least 1");
      end
   endgenerate

   logic              rst_all_n;
   logic              run, irq_en, kick, bite_fire, status;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] bark_t, bite_t;

   assign rst_all_n = por_n & sys_rst_n;

   dsw_regs #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .CNT_W  (CNT_W),
      .ALT_MAP(ALT_MAP)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_all_n),
      .por_n      (por_n),
      .wr_i       (wr_en),
      .rd_i       (rd_en),
      .addr_i     (addr),
      .wdata_i    (wr_data),
      .rdata_o    (rd_data),
      .cnt_i      (cnt),
      .bite_fire_i(bite_fire),
      .run_o      (run),
      .irq_en_o   (irq_en),
      .bark_t_o   (bark_t),
      .bite_t_o   (bite_t),
      .kick_o     (kick),
      .status_o   (status)
   );

   dsw_counter #(
      .CNT_W(CNT_W)
   ) u_counter (
      .clk   (clk),
      .rst_n (rst_all_n),
      .run_i (run),
      .kick_i(kick),
      .cnt_o (cnt)
   );

   dsw_alarm #(
      .CNT_W    (CNT_W),
      .DATA_W   (DATA_W),
      .PULSE_CYC(PULSE_CYC)
   ) u_alarm (
      .clk        (clk),
      .rst_n      (rst_all_n),
      .run_i      (run),
      .irq_en_i   (irq_en),
      .kick_i     (kick),
      .cnt_i      (cnt),
      .bark_t_i   (bark_t),
      .bite_t_i   (bite_t),
      .bark_irq_o (bark_irq),
      .bite_req_o (bite_req),
      .bite_fire_o(bite_fire)
   );

   assert_flag_on_bite_R11 : assert property (@(posedge clk) disable iff (!rst_all_n)
      $rose(bite_req) |-> status);

   assert_bark_needs_run_R7 : assert property (@(posedge clk) disable iff (!rst_all_n)
      $rose(bark_irq) |-> $past(run && irq_en));

endmodule

// File: tb/dual_stage_watchdog_test.sv
`timescale 1ns/1ps
module dual_stage_watchdog_test;

   localparam int AW = 8;
   localparam int DW = 32;
   localparam int CW = 8;
   localparam int PC = 3;

   localparam logic [AW-1:0] A_KICK = 8'h04, A_CTRL = 8'h08, A_STAT = 8'h0C,
                             A_BARK = 8'h10, A_BITE = 8'h14;
   localparam logic [AW-1:0] B_CTRL = 8'h40, B_KICK = 8'h38, B_BARK = 8'h4C;

   logic          clk = 1'b0;
   logic          por_n = 1'b0, sys_rst_n = 1'b0;
   logic          wr_en = 1'b0, rd_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data, rd_data_alt;
   logic          bark_irq, bite_req, bark_alt, bite_alt;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   dual_stage_watchdog #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .PULSE_CYC(PC), .ALT_MAP(1'b0)) uut (
      .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .bark_irq(bark_irq), .bite_req(bite_req));

   dual_stage_watchdog #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .PULSE_CYC(PC), .ALT_MAP(1'b1)) uut_alt (
      .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wr_data(wr_data), .rd_data(rd_data_alt), .bark_irq(bark_alt), .bite_req(bite_alt));

   task automatic chk(input string req, input string what, input longint got, input longint exp);
      n_chk++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
      end
   endtask

   // write captured at the posedge inside; returns at the following negedge
   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // started after edge Pj, returns the value the design held after P(j+1)
   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic [DW-1:0] d_alt);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      d = rd_data; d_alt = rd_data_alt;
   endtask

   task automatic arm(input int bark_t, input int bite_t, input logic [1:0] ctl);
      wr(A_CTRL, 0);
      wr(A_KICK, 1);
      wr(A_BARK, bark_t);
      wr(A_BITE, bite_t);
      wr(A_CTRL, {30'd0, ctl});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [DW-1:0] v, va;

      repeat (3) @(negedge clk);
      por_n = 1'b1; sys_rst_n = 1'b1;

      // R1 reset state
      chk("R1", "bark after por", bark_irq, 0);
      chk("R1", "bite after por", bite_req, 0);
      rd(A_CTRL, v, va); chk("R1", "ctrl", v, 0);
      rd(A_KICK, v, va); chk("R1", "count", v, 0);
      rd(A_BARK, v, va); chk("R1", "bark thr", v, 0);
      rd(A_BITE, v, va); chk("R1", "bite thr", v, 0);
      rd(A_STAT, v, va); chk("R1", "status", v, 0);

      // R12 unmapped access; R2 readback at default offsets
      wr(8'h20, 32'hFFFF_FFFF);
      wr(8'h18, 32'h3);
      rd(A_CTRL, v, va); chk("R12", "ctrl after unmapped write", v, 0);
      rd(A_BARK, v, va); chk("R12", "bark after unmapped write", v, 0);
      rd(8'h20, v, va);  chk("R12", "unmapped read", v, 0);
      wr(A_BARK, 32'h1234_5678);
      rd(A_BARK, v, va); chk("R2", "bark thr readback", v, 32'h1234_5678);
      wr(A_BITE, 32'h0000_00A5);
      rd(A_BITE, v, va); chk("R2", "bite thr readback", v, 32'hA5);
      wr(A_CTRL, 32'h2);
      rd(A_CTRL, v, va); chk("R2", "ctrl readback", v, 2);

      // R7/R9 sweep: both thresholds, bark before bite
      for (int b = 0; b <= 6; b++) begin
         int t = b + 3;
         arm(b, t, 2'b11);
         for (int k = 1; k <= t + 6; k++) begin
            @(negedge clk);
            chk("R7", $sformatf("bark b=%0d k=%0d", b, k), bark_irq, (k >= b + 1));
            chk("R9", $sformatf("bite t=%0d k=%0d", t, k), bite_req, (k >= t + 1 && k <= t + PC));
         end
      end

      // R8/R9 sweep: interrupt disabled, bite thresholds including zero
      for (int t = 0; t <= 4; t++) begin
         arm(0, t, 2'b01);
         for (int k = 1; k <= t + 8; k++) begin
            @(negedge clk);
            chk("R8", $sformatf("bark gated t=%0d k=%0d", t, k), bark_irq, 0);
            chk("R9", $sformatf("bite t=%0d k=%0d", t, k), bite_req, (k >= t + 1 && k <= t + PC));
         end
      end

      // R4 keep-alive, R5 count readback, R10 stop
      arm(10, 20, 2'b11);
      repeat (8) @(negedge clk);          // N8
      wr(A_KICK, 1);                      // cleared at P10, now at N10 -> new N0
      for (int k = 1; k <= 9; k++) begin
         @(negedge clk);
         chk("R4", $sformatf("bark after kick k=%0d", k), bark_irq, 0);
      end
      wr(A_KICK, 32'h2);                  // bit0 clear: no effect; now at N11
      chk("R4", "bark survives bit0=0 write", bark_irq, 1);
      rd(A_KICK, v, va); chk("R5", "count readback", v, 12);
      wr(A_CTRL, 0);                      // takes effect at P15
      @(negedge clk);
      chk("R10", "bark dropped on stop", bark_irq, 0);
      repeat (30) @(negedge clk);
      chk("R10", "no bite while stopped", bite_req, 0);
      rd(A_KICK, v, va); chk("R10", "count frozen", v, 15);

      // R6 saturation and bite at the top of the range
      arm(255, 255, 2'b01);
      for (int k = 1; k <= 300; k++) begin
         @(negedge clk);
         if (k >= 250)
            chk("R9", $sformatf("bite sat k=%0d", k), bite_req, (k >= 256 && k <= 255 + PC));
      end
      rd(A_KICK, v, va); chk("R6", "count saturated", v, 255);
      repeat (20) @(negedge clk);
      rd(A_KICK, v, va); chk("R6", "count still saturated", v, 255);

      // R11 bite flag across resets
      rd(A_STAT, v, va); chk("R11", "flag after bite", v, 1);
      @(negedge clk); sys_rst_n = 1'b0;
      @(negedge clk); sys_rst_n = 1'b1;
      rd(A_STAT, v, va); chk("R11", "flag after sys reset", v, 1);
      rd(A_CTRL, v, va); chk("R11", "ctrl after sys reset", v, 0);
      rd(A_KICK, v, va); chk("R11", "count after sys reset", v, 0);
      wr(A_STAT, 0);
      rd(A_STAT, v, va); chk("R11", "flag not writable", v, 1);
      @(negedge clk); por_n = 1'b0;
      @(negedge clk); por_n = 1'b1;
      rd(A_STAT, v, va); chk("R11", "flag after por", v, 0);

      // R3 alternate layout
      wr(B_CTRL, 0);
      wr(B_KICK, 1);
      wr(B_BARK, 5);
      wr(B_CTRL, 3);
      rd(B_BARK, v, va);
      chk("R3", "alt bark thr readback", va, 5);
      chk("R3", "default map ignores alt offset", v, 0);
      rd(B_CTRL, v, va); chk("R3", "alt ctrl readback", va, 3);
      repeat (10) @(negedge clk);
      chk("R3", "alt bark raised", bark_alt, 1);
      chk("R3", "default bark untouched", bark_irq, 0);

      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule